// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Generator

This block produces two pulse-width-modulated outputs whose pulses sit centred in the period. A 16-bit counter advances one step on every cycle where the tick-enable input is high. It climbs from zero to a ceiling value, then falls back to zero, and repeats. Each output channel compares the counter against its own threshold. The action taken on a match depends on whether the counter is rising or falling, so each pulse grows or shrinks by the same amount on both sides of the period's midpoint.

Software programs the block through a small write port with four addresses:

| Address | Contents |
|---|---|
| 0 | Control word |
| 1 | Period register |
| 2 | Channel A threshold buffer |
| 3 | Channel B threshold buffer |

The control word selects where the ceiling comes from and sets the polarity of each channel. Threshold writes are staged and only take effect at the ceiling turnaround. The counter value and its direction are visible on the ports. A one-cycle pulse marks each arrival at zero, and another marks each arrival at the ceiling. Prescaling of the tick is done outside the block.

Top module: `pwm_dual_slope`

## Requirements
- R1: After reset the counter and both staged and active thresholds are zero. The direction output is 1, meaning rising. Both PWM outputs and both flags are 0.
- R2: The counter changes only on a cycle with tick high, and then by exactly one. With tick low it holds its value.
- R3: Under continuous ticks the count runs 0,1,…,C,C−1,…,1,0,1,…, where C is the effective ceiling. Each end value appears for one tick, so a period is 2·C ticks. The direction output reads 1 at C and 0 at zero.
- R4: Control bits [2:0] select the ceiling source:

  | Code | Ceiling |
  |---|---|
  | 0 | 0x00FF |
  | 1 | 0x01FF |
  | 2 | 0x03FF |
  | 3 | The period register |
  | 4 | The active channel A threshold |
  | 5, 6, 7 | 0x00FF |

- R5: An effective ceiling below 3 is raised to 3. The counter never turns downward from a value below 3.
- R6: In normal polarity, a channel whose threshold T satisfies 0 < T < C goes low when the counter arrives at T while rising. It goes high when the counter arrives at T while falling. Over one period it is high for 2·T ticks.
- R7: Control bit 3 (channel A) and bit 4 (channel B) select inverted polarity. An inverted channel outputs the complement of its normal-polarity waveform.
- R8: A threshold of zero holds the channel at its inactive level for the whole period: low in normal polarity, high in inverted polarity. A threshold of C or more holds it at the active level.
- R9: Threshold writes go to a staging register. The staged value becomes active on the tick where the counter leaves the ceiling. Until then, the old threshold governs the output.
- R10: The zero flag is high for exactly the one cycle in which the counter shows zero after falling. The ceiling flag is high for the one cycle in which the counter shows C after rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 period, 2 threshold A, 3 threshold B |
| wr_data | input | W | Write data |
| count | output | W | Current counter value |
| dir_up | output | 1 | 1 while rising, 0 while falling |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| zero_flag | output | 1 | Pulse on arrival at zero |
| ceil_flag | output | 1 | Pulse on arrival at the ceiling |

## Verification
The assertions check the following on every cycle:
- The counter moves by exactly one per tick and holds without one.
- The counter always reverses at zero, and never reverses from below 3.
- Each flag appears only with the matching count and direction, and the zero flag never lasts two cycles.

Several behaviours depend on a configured threshold and the whole period, so only the bench scenarios can show them. These are the exact high-tick totals, the polarity inversion, the held levels at the threshold extremes, the choice of ceiling source, and the deferral of a threshold written mid-period.

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         zero_flag,
  output logic         ceil_flag
);
  localparam logic [W-1:0] CEIL8   = W'(16'h00FF);
  localparam logic [W-1:0] CEIL9   = W'(16'h01FF);
  localparam logic [W-1:0] CEIL10  = W'(16'h03FF);
  localparam logic [W-1:0] CEILMIN = W'(3);
  localparam logic [W-1:0] ONE     = W'(1);

  logic [4:0]   ctrl;
  logic [W-1:0] period, stage_a, stage_b, act_a, act_b, cnt;
  logic         up, lvl_a, lvl_b, zf, cf;
  logic [W-1:0] ceil_src, ceil, nxt_cnt, thr_a, thr_b;
  logic         nxt_up, turn, load;

  always_comb begin
    case (ctrl[2:0])
      3'd1:    ceil_src = CEIL9;
      3'd2:    ceil_src = CEIL10;
      3'd3:    ceil_src = period;
      3'd4:    ceil_src = act_a;
      default: ceil_src = CEIL8;
    endcase
  end

  assign ceil  = (ceil_src < CEILMIN) ? CEILMIN : ceil_src;
  assign turn  = up && (cnt >= ceil);
  assign load  = tick && turn;
  assign thr_a = load ? stage_a : act_a;
  assign thr_b = load ? stage_b : act_b;

  always_comb begin
    if (up) begin
      nxt_up  = !turn;
      nxt_cnt = turn ? cnt - ONE : cnt + ONE;
    end else if (cnt == '0) begin
      nxt_up  = 1'b1;
      nxt_cnt = ONE;
    end else begin
      nxt_up  = 1'b0;
      nxt_cnt = cnt - ONE;
    end
  end

  function automatic logic next_lvl(input logic [W-1:0] thr, input logic cur,
                                    input logic [W-1:0] top, input logic [W-1:0] c,
                                    input logic rising);
    if (thr == '0)   return 1'b0;
    if (thr >= top)  return 1'b1;
    if (c == thr)    return !rising;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      period  <= '0;
      stage_a <= '0;
      stage_b <= '0;
      act_a   <= '0;
      act_b   <= '0;
      cnt     <= '0;
      up      <= 1'b1;
      lvl_a   <= 1'b0;
      lvl_b   <= 1'b0;
      zf      <= 1'b0;
      cf      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: ctrl    <= wr_data[4:0];
          2'd1: period  <= wr_data;
          2'd2: stage_a <= wr_data;
          default: stage_b <= wr_data;
        endcase
      end
      zf <= tick && (nxt_cnt == '0);
      cf <= tick && up && !turn && (nxt_cnt == ceil);
      if (tick) begin
        cnt   <= nxt_cnt;
        up    <= nxt_up;
        lvl_a <= next_lvl(thr_a, lvl_a, ceil, nxt_cnt, nxt_up);
        lvl_b <= next_lvl(thr_b, lvl_b, ceil, nxt_cnt, nxt_up);
        if (load) begin
          act_a <= stage_a;
          act_b <= stage_b;
        end
      end
    end
  end

  assign count     = cnt;
  assign dir_up    = up;
  assign pwm_a     = lvl_a ^ ctrl[3];
  assign pwm_b     = lvl_b ^ ctrl[4];
  assign zero_flag = zf;
  assign ceil_flag = cf;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + ONE) || (count == $past(count) - ONE));

  p_bounce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir_up && count == '0) |=> (dir_up && count == ONE));

  p_min_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_up && count < CEILMIN) |=> dir_up);

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> (count == '0 && !dir_up));

  p_zero_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |=> !zero_flag);

  p_ceil_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_flag |-> (dir_up && count >= CEILMIN));
endmodule

// File: tb/pwm_dual_slope_tb.sv
module pwm_dual_slope_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        dir_up, pwm_a, pwm_b, zero_flag, ceil_flag;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwm_dual_slope #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .dir_up(dir_up), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .zero_flag(zero_flag), .ceil_flag(ceil_flag)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    tick = 1'b0;
    wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1;
    wr_addr = 2'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int sel, input int inva, input int invb, input int per, input int ta, input int tb);
    do_reset();
    wr(0, sel | (inva << 3) | (invb << 4));
    wr(1, per);
    wr(2, ta);
    wr(3, tb);
  endtask

  function automatic int expect_lvl(input int c, input int rising, input int thr, input int top, input int inv);
    int l;
    if (thr == 0) l = 0;
    else if (thr >= top) l = 1;
    else if (rising != 0) l = (c < thr) ? 1 : 0;
    else l = (c <= thr) ? 1 : 0;
    return l ^ inv;
  endfunction

  task automatic measure(input int top, input int ta, input int tb, input int inva, input int invb,
                         output int hi_a, output int hi_b, output int len, output int maxc, output int bad);
    int guard;
    hi_a = 0; hi_b = 0; len = 0; maxc = 0; bad = 0;
    tick = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!zero_flag && guard < 10000);
    guard = 0;
    do begin
      len++;
      if (int'(count) > maxc) maxc = int'(count);
      if (pwm_a) hi_a++;
      if (pwm_b) hi_b++;
      if (int'(pwm_a) != expect_lvl(int'(count), int'(dir_up), ta, top, inva)) bad++;
      if (int'(pwm_b) != expect_lvl(int'(count), int'(dir_up), tb, top, invb)) bad++;
      @(negedge clk);
      guard++;
    end while (!zero_flag && guard < 10000);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "count", count, 0);
    chk("R1", "dir_up", dir_up, 1);
    chk("R1", "pwm_a", pwm_a, 0);
    chk("R1", "pwm_b", pwm_b, 0);
    chk("R1", "zero_flag", zero_flag, 0);
    chk("R1", "ceil_flag", ceil_flag, 0);
  endtask

  task automatic t_hold();
    do_reset();
    repeat (4) @(negedge clk);
    chk("R2", "count idle", count, 0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R2", "count one tick", count, 1);
    repeat (3) @(negedge clk);
    chk("R2", "count held", count, 1);
  endtask

  task automatic t_sweep();
    int ec = 0;
    int eu = 1;
    cfg(3, 0, 0, 5, 0, 0);
    tick = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (eu != 0) begin
        if (ec >= 5) begin ec--; eu = 0; end
        else ec++;
      end else if (ec == 0) begin
        ec = 1; eu = 1;
      end else ec--;
      @(negedge clk);
      chk("R3", "count", count, ec);
      chk("R3", "dir_up", dir_up, eu);
      chk("R10", "zero_flag", zero_flag, (ec == 0) ? 1 : 0);
      chk("R10", "ceil_flag", ceil_flag, (ec == 5 && eu == 1) ? 1 : 0);
    end
    tick = 1'b0;
  endtask

  task automatic t_clamp();
    int ha, hb, len, mx, bad;
    cfg(3, 0, 0, 1, 0, 0);
    measure(3, 0, 0, 0, 0, ha, hb, len, mx, bad);
    chk("R5", "period len, reg=1", len, 6);
    chk("R5", "max count, reg=1", mx, 3);
    cfg(3, 0, 0, 0, 0, 0);
    measure(3, 0, 0, 0, 0, ha, hb, len, mx, bad);
    chk("R5", "period len, reg=0", len, 6);
    chk("R5", "max count, reg=0", mx, 3);
  endtask

  task automatic t_fixed();
    int ha, hb, len, mx, bad;
    int sels[4] = '{0, 1, 2, 6};
    int tops[4] = '{255, 511, 1023, 255};
    for (int k = 0; k < 4; k++) begin
      cfg(sels[k], 0, 0, 7, 0, 0);
      measure(tops[k], 0, 0, 0, 0, ha, hb, len, mx, bad);
      chk("R4", "fixed ceiling period", len, 2 * tops[k]);
      chk("R4", "fixed ceiling max", mx, tops[k]);
    end
    cfg(4, 0, 0, 100, 6, 2);
    measure(6, 6, 2, 0, 0, ha, hb, len, mx, bad);
    chk("R4", "threshold-A ceiling period", len, 12);
    chk("R4", "threshold-A ceiling max", mx, 6);
    chk("R6", "threshold-A ceiling, B high ticks", hb, 4);
  endtask

  task automatic t_duty();
    int ha, hb, len, mx, bad;
    cfg(3, 0, 1, 10, 4, 7);
    measure(10, 4, 7, 0, 1, ha, hb, len, mx, bad);
    chk("R6", "A normal high ticks", ha, 8);
    chk("R7", "B inverted high ticks", hb, 6);
    chk("R6", "pointwise mismatches", bad, 0);
    cfg(3, 1, 0, 12, 3, 11);
    measure(12, 3, 11, 1, 0, ha, hb, len, mx, bad);
    chk("R7", "A inverted high ticks", ha, 18);
    chk("R6", "B normal high ticks", hb, 22);
    chk("R7", "pointwise mismatches", bad, 0);
  endtask

  task automatic t_edges();
    int ha, hb, len, mx, bad;
    cfg(3, 0, 0, 8, 0, 8);
    measure(8, 0, 8, 0, 0, ha, hb, len, mx, bad);
    chk("R8", "zero threshold normal", ha, 0);
    chk("R8", "ceiling threshold normal", hb, 16);
    chk("R8", "pointwise mismatches", bad, 0);
    cfg(3, 1, 1, 8, 0, 40);
    measure(8, 0, 40, 1, 1, ha, hb, len, mx, bad);
    chk("R8", "zero threshold inverted", ha, 16);
    chk("R8", "above ceiling inverted", hb, 0);
  endtask

  task automatic t_buffer();
    int guard;
    cfg(3, 0, 0, 10, 4, 0);
    tick = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!zero_flag && guard < 100);
    wr(2, 8);
    guard = 0;
    while (!(count == 16'd5 && dir_up) && guard < 100) begin @(negedge clk); guard++; end
    chk("R9", "pwm_a at 5 rising keeps old threshold", pwm_a, 0);
    guard = 0;
    while (!(count == 16'd9 && !dir_up) && guard < 100) begin @(negedge clk); guard++; end
    chk("R9", "pwm_a at 9 falling", pwm_a, 0);
    @(negedge clk);
    chk("R9", "count after 9 falling", count, 8);
    chk("R9", "pwm_a at 8 falling uses new threshold", pwm_a, 1);
    tick = 1'b0;
  endtask

  initial begin
    t_reset();
    t_hold();
    t_sweep();
    t_clamp();
    t_fixed();
    t_duty();
    t_edges();
    t_buffer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule